// File: doc/BRIEF.md
# Serial Output Write Buffer

This block holds up to 256 bits that software loads four bits at a time, and shifts them out on a serial clock line and a serial data line. The pace of the shift comes from one of four prescaler tick inputs. Each tick moves the serial clock by half a period. The data bits leave least significant bit first, and the data line changes only while the clock is low, so that a receiver can sample on the rising clock edge.

The block has two send modes. In automatic mode, software fills the buffer, sets a length and starts the transfer. The block then sends the programmed number of bits without further help. In interactive mode, the buffer works as a nibble queue. Each time the queue runs dry, the block pulses an interrupt and holds the clock low. Software can then add more nibbles and the transfer carries on. If nothing arrives before the next tick of the selected tap, the transfer ends.

The register interface has four write slots: data, control, low length nibble and high length nibble. A busy output reports whether a transfer is in progress.

Top module: `swb_top`

## Requirements
- R1: After reset, ser_clk, ser_data, busy and empty_irq are all 0.
- R2: A write to slot 0 (data) stores the nibble at the write pointer and advances the pointer. Bits are sent in nibble write order, each nibble from bit 0 to bit 3, so the first bit sent is bit 0 of the first nibble.
- R3: Slot 2 sets length bits [3:0] and slot 3 sets length bits [7:4]. An automatic transfer sends length+1 bits, so any count from 1 to 256 can be sent.
- R4: Slot 1 (control) carries the tap select in bits [1:0], the mode in bit 2 (1 = interactive) and start in bit 3. A control write with bit 3 at 0 while idle stores the configuration and rewinds the write pointer to the first nibble.
- R5: In a transfer, ser_clk toggles only on a tick of the selected tap_tick bit, so its period is two tap periods. ser_clk is low whenever busy is 0.
- R6: ser_data changes only while ser_clk is low and holds its value for the whole high phase.
- R7: busy goes to 1 on the clock edge that accepts a start write and returns to 0 at the falling serial clock edge that ends the last bit.
- R8: Automatic mode sends whatever the buffer holds, whatever the write pointer says, and never raises empty_irq.
- R9: In interactive mode, empty_irq pulses for one cycle when the queue becomes empty. This includes a start with an empty queue. A nibble written afterwards resumes the transfer.
- R10: In interactive mode, if the queue is still empty at the next tick of the selected tap after empty_irq, the transfer ends with ser_clk low.
- R11: When 64 nibbles are pending, further data writes are ignored and do not overwrite the buffer.
- R12: Control and length writes made while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_tick | input | 4 | One-cycle tick pulses from four prescaler taps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write slot: 0 data, 1 control, 2 length low, 3 length high |
| wr_data | input | 4 | Write nibble |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, LSB first |
| busy | output | 1 | Transfer in progress |
| empty_irq | output | 1 | One-cycle pulse when the interactive queue runs dry |

## Verification
The bench targets the ends of the length range: a single bit, and the full 256 bits. An off-by-one in the length compare shows up as one bit too many or too few. The bench also overfills the queue. A design without the full guard overwrites the first nibble with the 65th, so the next transfer sends the wrong value.

Control and length writes made during a transfer must leave the bit count and the clock rate unchanged. The interactive runs cover a refill inside the grace window and a start with an empty queue. A design that ends too early drops the refilled nibble. A design that never ends hangs with busy high.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam int NIB  = 4;
    localparam int TAPS = 4;

    typedef enum logic [1:0] {
        SLOT_DATA   = 2'd0,
        SLOT_CTRL   = 2'd1,
        SLOT_LEN_LO = 2'd2,
        SLOT_LEN_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic       go;
        logic       inter;
        logic [1:0] tap;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD
    } eng_e;

    function automatic logic tap_pick(input logic [TAPS-1:0] ticks, input logic [1:0] sel);
        return ticks[sel];
    endfunction
endpackage

// File: rtl/swb_regs.sv
module swb_regs
    import swb_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  slot_e                     wr_slot,
    input  logic [NIB-1:0]            wr_data,
    input  logic                      busy,
    input  logic [$clog2(DEPTH)-2:0]  rd_nib,
    output logic [DEPTH-1:0]          bits,
    output logic [$clog2(DEPTH)-2:0]  wptr,
    output logic [$clog2(DEPTH)-1:0]  len,
    output ctrl_t                     cfg,
    output logic                      start_p,
    output logic                      rewind_p
);
    localparam int PW    = $clog2(DEPTH);
    localparam int NW    = PW - 2;
    localparam int SLOTS = DEPTH / NIB;
    localparam logic [NW:0] FULLV = (NW+1)'(SLOTS);

    logic full;
    logic ctrl_wr;

    assign full     = ((wptr - rd_nib) == FULLV);
    assign ctrl_wr  = wr_en && (wr_slot == SLOT_CTRL) && !busy;
    assign start_p  = ctrl_wr && wr_data[3];
    assign rewind_p = ctrl_wr && !wr_data[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
            wptr <= '0;
            len  <= '0;
            cfg  <= '0;
        end else if (wr_en) begin
            unique case (wr_slot)
                SLOT_DATA: begin
                    if (!full) begin
                        bits[{wptr[NW-1:0], 2'b00} +: NIB] <= wr_data;
                        wptr <= wptr + 1'b1;
                    end
                end
                SLOT_CTRL: begin
                    if (!busy) begin
                        cfg <= ctrl_t'(wr_data);
                        if (!wr_data[3]) wptr <= '0;
                    end
                end
                SLOT_LEN_LO: begin
                    if (!busy) len[3:0] <= wr_data;
                end
                SLOT_LEN_HI: begin
                    if (!busy) len <= PW'({wr_data, len[3:0]});
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/swb_engine.sv
module swb_engine
    import swb_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      inter,
    input  logic [$clog2(DEPTH)-1:0]  len,
    input  logic [DEPTH-1:0]          bits,
    input  logic [$clog2(DEPTH)-2:0]  wptr,
    input  logic                      start_p,
    input  logic                      rewind_p,
    output logic                      sclk,
    output logic                      sdata,
    output logic                      busy,
    output logic                      irq,
    output logic [$clog2(DEPTH)-2:0]  rd_nib
);
    localparam int PW = $clog2(DEPTH);

    eng_e        st;
    logic [PW:0] bp;
    logic [PW:0] nbp;
    logic        empty;
    logic        nempty;

    assign rd_nib = bp[PW:2];
    assign nbp    = bp + 1'b1;
    assign empty  = (bp[PW:2] == wptr);
    assign nempty = (nbp[PW:2] == wptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            bp    <= '0;
            sclk  <= 1'b0;
            sdata <= 1'b0;
            busy  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_p) begin
                        bp   <= '0;
                        busy <= 1'b1;
                        if (inter && (wptr == '0)) begin
                            st  <= ST_HOLD;
                            irq <= 1'b1;
                        end else begin
                            sdata <= bits[0];
                            st    <= ST_SHIFT;
                        end
                    end else if (rewind_p) begin
                        bp <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            bp   <= nbp;
                            if (!inter) begin
                                if (bp[PW-1:0] == len) begin
                                    st    <= ST_IDLE;
                                    busy  <= 1'b0;
                                    sdata <= 1'b0;
                                end else begin
                                    sdata <= bits[nbp[PW-1:0]];
                                end
                            end else if (nempty) begin
                                st  <= ST_HOLD;
                                irq <= 1'b1;
                            end else begin
                                sdata <= bits[nbp[PW-1:0]];
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (!empty) begin
                        sdata <= bits[bp[PW-1:0]];
                        st    <= ST_SHIFT;
                    end else if (tick) begin
                        st    <= ST_IDLE;
                        busy  <= 1'b0;
                        sdata <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swb_top.sv
module swb_top
    import swb_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  tap_tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [3:0]  wr_data,
    output logic        ser_clk,
    output logic        ser_data,
    output logic        busy,
    output logic        empty_irq
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0] bits;
    logic [PW-2:0]    wptr;
    logic [PW-2:0]    rd_nib;
    logic [PW-1:0]    len;
    ctrl_t            cfg;
    logic             start_p;
    logic             rewind_p;
    logic             tick;
    logic [1:0]       cfg_tap;
    logic             cfg_inter;

    assign cfg_tap   = cfg.tap;
    assign cfg_inter = cfg.inter;
    assign tick      = tap_pick(tap_tick, cfg.tap);

    swb_regs #(.DEPTH(DEPTH)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_slot  (slot_e'(wr_addr)),
        .wr_data  (wr_data),
        .busy     (busy),
        .rd_nib   (rd_nib),
        .bits     (bits),
        .wptr     (wptr),
        .len      (len),
        .cfg      (cfg),
        .start_p  (start_p),
        .rewind_p (rewind_p)
    );

    swb_engine #(.DEPTH(DEPTH)) i_engine (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .inter    (cfg.inter),
        .len      (len),
        .bits     (bits),
        .wptr     (wptr),
        .start_p  (start_p),
        .rewind_p (rewind_p),
        .sclk     (ser_clk),
        .sdata    (ser_data),
        .busy     (busy),
        .irq      (empty_irq),
        .rd_nib   (rd_nib)
    );
endmodule

// File: rtl/swb_checker.sv
module swb_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] tap_tick,
    input logic [1:0] tap,
    input logic       inter,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [3:0] wr_data,
    input logic       sclk,
    input logic       sdata,
    input logic       busy,
    input logic       irq
);
    a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(tap_tick[tap]));

    a_r6_data_steady_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdata));

    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && (wr_addr == 2'd1) && wr_data[3]));

    a_r8_auto_no_irq: assert property (@(posedge clk) disable iff (rst)
        irq |-> inter);

    a_r9_irq_clock_low: assert property (@(posedge clk) disable iff (rst)
        irq |-> (busy && !sclk));
endmodule

bind swb_top swb_checker i_swb_chk (
    .clk      (clk),
    .rst      (rst),
    .tap_tick (tap_tick),
    .tap      (cfg_tap),
    .inter    (cfg_inter),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sclk     (ser_clk),
    .sdata    (ser_data),
    .busy     (busy),
    .irq      (empty_irq)
);

// File: tb/test_swb_top.sv
`timescale 1ns/1ps
module test_swb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tap_tick = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       ser_clk, ser_data, busy, empty_irq;

    localparam int P [4] = '{3, 5, 7, 9};
    // fields: tap [25:24], length [23:16], data [15:0]
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 8'd15, 16'hA5C3},
        {2'd1, 8'd7,  16'h003C},
        {2'd2, 8'd0,  16'h0001},
        {2'd3, 8'd10, 16'h05F6},
        {2'd0, 8'd3,  16'h000E},
        {2'd1, 8'd12, 16'h1234}
    };

    int  nchk = 0, nfail = 0;
    int  cyc = 0, ncap = 0, nirq = 0, last_rise = -1, period = 0, viol = 0;
    logic cap [0:511];
    logic prev_clk = 1'b0, prev_data = 1'b0;

    swb_top i_swb_top (
        .clk(clk), .rst(rst), .tap_tick(tap_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ser_clk(ser_clk),
        .ser_data(ser_data), .busy(busy), .empty_irq(empty_irq)
    );

    always #2.5 clk = ~clk;

    // receiver model and tap tick source, both away from the active edge
    always @(negedge clk) begin
        if (ser_clk && !prev_clk) begin
            if (ncap < 512) cap[ncap] = ser_data;
            ncap++;
            if (last_rise >= 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        if (ser_clk && prev_clk && (ser_data !== prev_data)) viol++;
        if (empty_irq) nirq++;
        prev_clk  = ser_clk;
        prev_data = ser_data;
        cyc++;
        for (int k = 0; k < 4; k++) tap_tick[k] = ((cyc % P[k]) == 0);
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_mon;
        ncap = 0; nirq = 0; last_rise = -1; period = 0; viol = 0;
    endtask

    task automatic wait_idle;
        for (int t = 0; t < 6000 && busy; t++) @(negedge clk);
    endtask

    function automatic int cap_val(input int n);
        int v = 0;
        for (int i = 0; i < n && i < 31; i++) v |= int'(cap[i]) << i;
        return v;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ser_clk", int'(ser_clk), 0);
        check("R1 ser_data", int'(ser_data), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 empty_irq", int'(empty_irq), 0);

        // table of automatic transfers
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  sel = VEC[v][25:24];
            logic [7:0]  ln  = VEC[v][23:16];
            logic [15:0] dat = VEC[v][15:0];
            int nb = int'(ln) + 1;
            wr(2'd1, {2'b00, sel});               // R4 rewind + config
            for (int n = 0; n < 4; n++) wr(2'd0, dat[n*4 +: 4]);
            wr(2'd2, ln[3:0]);
            wr(2'd3, ln[7:4]);
            clear_mon();
            wr(2'd1, {2'b10, sel});
            check("R7 busy after start", int'(busy), 1);
            wait_idle();
            check("R3 bit count", ncap, nb);
            check("R2 LSB-first value", cap_val(nb), int'(dat) & ((1 << nb) - 1));
            if (nb > 1) check("R5 clock period", period, 2 * P[sel]);
            check("R5 idle low", int'(ser_clk), 0);
            check("R8 no irq in automatic", nirq, 0);
            check("R6 data steady while high", viol, 0);
        end

        // R3 full 256-bit transfer
        wr(2'd1, 4'b0000);
        for (int n = 0; n < 64; n++) wr(2'd0, 4'((n * 7 + 3) & 15));
        wr(2'd2, 4'hF);
        wr(2'd3, 4'hF);
        clear_mon();
        wr(2'd1, 4'b1000);
        wait_idle();
        check("R3 256-bit count", ncap, 256);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++)
                if (cap[i] !== 1'(((i / 4) * 7 + 3) >> (i % 4))) bad++;
            check("R2 256-bit content", bad, 0);
        end

        // R11 65th nibble ignored when full
        wr(2'd1, 4'b0000);
        for (int n = 0; n < 64; n++) wr(2'd0, 4'h5);
        wr(2'd0, 4'hA);
        wr(2'd2, 4'h3);
        wr(2'd3, 4'h0);
        clear_mon();
        wr(2'd1, 4'b1000);
        wait_idle();
        check("R11 first nibble kept", cap_val(4), 5);

        // R12 control and length writes ignored while busy
        wr(2'd1, 4'b0011);
        wr(2'd0, 4'h6);
        wr(2'd0, 4'h9);
        wr(2'd2, 4'h7);
        wr(2'd3, 4'h0);
        clear_mon();
        wr(2'd1, 4'b1011);
        repeat (5) @(negedge clk);
        wr(2'd1, 4'b1000);
        wr(2'd2, 4'h1);
        wait_idle();
        check("R12 count unchanged", ncap, 8);
        check("R12 period unchanged", period, 18);
        check("R12 value", cap_val(8), 8'h96);

        // R9 interactive refill inside the window
        wr(2'd1, 4'b0111);
        wr(2'd0, 4'hB);
        clear_mon();
        wr(2'd1, 4'b1111);
        for (int t = 0; t < 400 && nirq == 0; t++) @(negedge clk);
        check("R9 irq on empty", nirq, 1);
        wr(2'd0, 4'h6);
        wait_idle();
        check("R9 resumed count", ncap, 8);
        check("R9 resumed value", cap_val(8), 8'h6B);
        check("R10 second irq then stop", nirq, 2);
        check("R10 clock idle at stop", int'(ser_clk), 0);

        // R10 interactive start with empty queue
        wr(2'd1, 4'b0111);
        clear_mon();
        wr(2'd1, 4'b1111);
        wait_idle();
        check("R9 irq on empty start", nirq, 1);
        check("R10 no bits sent", ncap, 0);
        check("R10 busy cleared", int'(busy), 0);

        report();
    end
endmodule